// File: doc/BRIEF.md
# Clocked Serial Byte Transmitter

This block sends bytes over a two-wire synchronous link made of a data line and a shift clock. It serves a processor that writes characters through a single strobe. Bits leave least significant first. The shift clock can come from two sources. In the first, the block divides the system clock and drives the clock pin itself. In the second, another device drives the pin, and each transition that `edge_sel` selects moves the data line on to the next bit.

In the driven-clock mode, each write to the idle block starts a full character. In the external-clock mode, a write fills a one-character holding register. The first selected edge after that moves the character into the shifter and frees the holding register, so the processor can place the next character there while the current one is still going out. Either mode marks the end of a character with a one-cycle completion pulse and a sticky completion flag. A selected edge that finds nothing to send leaves the line high and sets an underrun flag.

The clock pin is modelled as three signals: `sclk_i`, `sclk_o` and an output enable `sclk_oe`. The external clock passes through two synchronizer flops and then an edge detector. It must run slower than a quarter of the system clock rate. `clk_sel` and `edge_sel` may only change while no character is in progress.

Top module: `sio_tx`

## Requirements
- R1: After reset, txd is 1, sclk_o is 1, done_pulse is 0, done_flag is 0 and underrun is 0.
- R2: With clk_sel=1, a write while idle starts a character. Counting the write edge as edge 0, txd carries bit k of the written byte (k=0 for the LSB) from edge 2*k*DIV_HALF until edge 2*(k+1)*DIV_HALF.
- R3: With clk_sel=1, sclk_oe is 1. Within each bit period, sclk_o is 0 for the first DIV_HALF cycles and 1 for the next DIV_HALF cycles, and it is 1 while idle. With clk_sel=0, sclk_oe is 0 and sclk_o stays 1.
- R4: With clk_sel=1, done_pulse is 1 for exactly one cycle, following edge 16*DIV_HALF. txd returns to 1 at that same edge.
- R5: With clk_sel=1, a write during a character in progress is ignored, and the character continues unchanged.
- R6: With clk_sel=0, each selected edge of sclk_i (edge_sel=0: rising, edge_sel=1: falling) drives the next bit on txd. The first selected edge after a write drives bit 0 and the eighth drives bit 7. txd settles within four system cycles of the pin change.
- R7: With clk_sel=0, transitions of sclk_i in the non-selected direction leave txd unchanged.
- R8: With clk_sel=0, the holding register frees at the first selected edge of a character. A byte written after that edge is sent starting at the ninth selected edge, with no gap.
- R9: With clk_sel=0, done_pulse occurs once per character, after the eighth selected edge and at no other edge.
- R10: With clk_sel=0, a selected edge that starts a character while the holding register is empty sets txd to 1 and sets underrun. underrun stays set until the next write, which clears it.
- R11: done_flag sets when a character completes, stays set while no write occurs, and is cleared by a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the transmit byte |
| wr_data | input | 8 | Byte to transmit |
| clk_sel | input | 1 | 1: block drives the shift clock, 0: shift clock comes from outside |
| edge_sel | input | 1 | Active external edge, 0 rising, 1 falling |
| sclk_i | input | 1 | Shift clock pin, input side |
| sclk_o | output | 1 | Shift clock pin, output side (idle high) |
| sclk_oe | output | 1 | Output enable for the shift clock pin |
| txd | output | 1 | Serial data out (idle high) |
| done_pulse | output | 1 | One-cycle character-complete pulse |
| done_flag | output | 1 | Sticky character-complete flag |
| underrun | output | 1 | Selected edge found no byte to send |

## Verification
The hardest situation to reach is a character handover in external-clock mode. A byte has to be written after the first selected edge of the current character, and the eight edges of the following character then have to arrive without a gap. One more edge then has to find the holding register empty. The bench produces this by toggling sclk_i slowly enough for the synchronizer to settle, and by inserting the second write right after the first selected edge. A second write falls in the middle of a driven-clock character, to confirm it is dropped. Both active-edge settings run with random bytes, next to directed all-zeros, all-ones and single-bit patterns.

// File: rtl/sio_tx_pkg.sv
package sio_tx_pkg;

    localparam int CHAR_W = 8;
    localparam int BIT_W  = $clog2(CHAR_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(CHAR_W - 1);

    typedef struct packed {
        logic [CHAR_W-1:0] shreg;
        logic [CHAR_W-1:0] hold;
        logic              hold_full;
        logic              busy;
        logic              xact;
        logic [BIT_W-1:0]  bitn;
        logic              txd;
        logic              sclk;
        logic              done;
        logic              flag;
        logic              urun;
    } tx_state_t;

endpackage

// File: rtl/sio_tx_edge.sv
module sio_tx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic fall_sel,
    output logic active
);
    typedef struct packed {
        logic [2:0] sync;
        logic [2:0] vld;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[1:0], pin_i};
        st_d.vld  = {st_q.vld[1:0], 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (!st_q.vld[2])  active = 1'b0;
        else if (fall_sel) active = st_q.sync[2] & ~st_q.sync[1];
        else               active = st_q.sync[1] & ~st_q.sync[2];
    end
endmodule

// File: rtl/sio_tx_div.sv
module sio_tx_div #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] TOP = CW'(HALF - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run)            cnt_d = '0;
        else if (cnt_q == TOP) cnt_d = '0;
        else                 cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = run && (cnt_q == TOP);
endmodule

// File: rtl/sio_tx.sv
module sio_tx
    import sio_tx_pkg::*;
#(
    parameter int DIV_HALF = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic              clk_sel,
    input  logic              edge_sel,
    input  logic              sclk_i,
    output logic              sclk_o,
    output logic              sclk_oe,
    output logic              txd,
    output logic              done_pulse,
    output logic              done_flag,
    output logic              underrun
);
    tx_state_t st_d, st_q;
    logic      tick;
    logic      ext_act;
    logic      int_busy;

    sio_tx_div #(.HALF(DIV_HALF)) div_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (clk_sel && st_q.busy),
        .tick  (tick)
    );

    sio_tx_edge edge_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_i    (sclk_i),
        .fall_sel (edge_sel),
        .active   (ext_act)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (clk_sel) begin
            // driven-clock mode
            if (!st_q.busy) begin
                if (wr_en) begin
                    st_d.busy  = 1'b1;
                    st_d.shreg = wr_data;
                    st_d.txd   = wr_data[0];
                    st_d.sclk  = 1'b0;
                    st_d.bitn  = '0;
                    st_d.flag  = 1'b0;
                    st_d.urun  = 1'b0;
                end
            end else if (tick) begin
                if (!st_q.sclk) begin
                    st_d.sclk = 1'b1;
                end else if (st_q.bitn == LAST_BIT) begin
                    st_d.busy = 1'b0;
                    st_d.txd  = 1'b1;
                    st_d.done = 1'b1;
                    st_d.flag = 1'b1;
                end else begin
                    st_d.bitn  = st_q.bitn + 1'b1;
                    st_d.shreg = st_q.shreg >> 1;
                    st_d.txd   = st_q.shreg[1];
                    st_d.sclk  = 1'b0;
                end
            end
        end else begin
            // external-clock mode
            st_d.sclk = 1'b1;
            if (ext_act) begin
                if (!st_q.xact) begin
                    if (st_q.hold_full) begin
                        st_d.shreg     = st_q.hold;
                        st_d.txd       = st_q.hold[0];
                        st_d.hold_full = 1'b0;
                        st_d.xact      = 1'b1;
                        st_d.bitn      = '0;
                    end else begin
                        st_d.txd  = 1'b1;
                        st_d.urun = 1'b1;
                    end
                end else begin
                    st_d.bitn  = st_q.bitn + 1'b1;
                    st_d.shreg = st_q.shreg >> 1;
                    st_d.txd   = st_q.shreg[1];
                    if (st_q.bitn == LAST_BIT - 1'b1) begin
                        st_d.xact = 1'b0;
                        st_d.done = 1'b1;
                        st_d.flag = 1'b1;
                    end
                end
            end
            if (wr_en) begin
                st_d.hold      = wr_data;
                st_d.hold_full = 1'b1;
                st_d.flag      = 1'b0;
                st_d.urun      = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.txd  <= 1'b1;
            st_q.sclk <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign int_busy   = st_q.busy;
    assign txd        = st_q.txd;
    assign sclk_o     = st_q.sclk;
    assign sclk_oe    = clk_sel;
    assign done_pulse = st_q.done;
    assign done_flag  = st_q.flag;
    assign underrun   = st_q.urun;
endmodule

// File: rtl/sio_tx_chk.sv
module sio_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic clk_sel,
    input logic wr_en,
    input logic busy,
    input logic txd,
    input logic sclk_o,
    input logic done_pulse,
    input logic done_flag,
    input logic underrun
);
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse); // R4

    AST_IDLE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel && !busy) |-> sclk_o); // R3

    AST_EXT_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_sel |-> sclk_o); // R3

    AST_TXD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel && busy && $past(busy) && !$fell(sclk_o)) |-> $stable(txd)); // R2

    AST_UNDERRUN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> txd); // R10

    AST_UNDERRUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !wr_en) |=> underrun); // R10

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && !wr_en) |=> done_flag); // R11
endmodule

bind sio_tx sio_tx_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_sel    (clk_sel),
    .wr_en      (wr_en),
    .busy       (int_busy),
    .txd        (txd),
    .sclk_o     (sclk_o),
    .done_pulse (done_pulse),
    .done_flag  (done_flag),
    .underrun   (underrun)
);

// File: tb/sio_tx_tb_top.sv
module sio_tx_tb_top;
    localparam int H = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       clk_sel = 1'b1;
    logic       edge_sel = 1'b0;
    logic       sclk_i = 1'b0;
    logic       sclk_o, sclk_oe, txd, done_pulse, done_flag, underrun;

    int n_chk = 0;
    int n_bad = 0;
    int pcnt = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    sio_tx #(.DIV_HALF(H)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .clk_sel(clk_sel), .edge_sel(edge_sel), .sclk_i(sclk_i),
        .sclk_o(sclk_o), .sclk_oe(sclk_oe), .txd(txd),
        .done_pulse(done_pulse), .done_flag(done_flag), .underrun(underrun)
    );

    always @(posedge clk) if (done_pulse) pcnt++;

    task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    function automatic logic exp_bit(logic [7:0] d, int k);
        return d[k];
    endfunction

    function automatic logic exp_sclk(int j);
        return ((j % (2 * H)) < H) ? 1'b0 : 1'b1;
    endfunction

    task automatic write_byte(logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic int_xfer(logic [7:0] d, bit poke);
        int pc0;
        pc0 = pcnt;
        write_byte(d);
        chk("R11", done_flag, 0);
        for (int j = 0; j <= 16 * H + 1; j++) begin
            if (j < 16 * H) begin
                chk((poke && j > 5) ? "R5" : "R2", txd, exp_bit(d, j / (2 * H)));
                chk("R3", sclk_o, exp_sclk(j));
                chk("R4", done_pulse, 0);
            end else if (j == 16 * H) begin
                chk("R4", done_pulse, 1);
                chk("R4", txd, 1);
                chk("R3", sclk_o, 1);
            end else begin
                chk("R4", done_pulse, 0);
            end
            if (poke && j == 5) begin wr_en = 1'b1; wr_data = ~d; end
            if (poke && j == 6) wr_en = 1'b0;
            @(negedge clk);
        end
        chk("R4", pcnt, pc0 + 1);
        chk("R11", done_flag, 1);
    endtask

    task automatic ext_edge(bit act);
        @(negedge clk);
        sclk_i = act ? ~edge_sel : edge_sel;
        repeat (4) @(negedge clk);
    endtask

    task automatic ext_char(logic [7:0] d, string tag, bit has_next, logic [7:0] dn);
        int pc;
        for (int k = 0; k < 8; k++) begin
            pc = pcnt;
            ext_edge(1'b1);
            chk(tag, txd, exp_bit(d, k));
            chk("R9", pcnt, (k == 7) ? pc + 1 : pc);
            if (k == 0 && has_next) write_byte(dn);
            ext_edge(1'b0);
            chk("R7", txd, exp_bit(d, k));
        end
    endtask

    task automatic ext_session(bit e, logic [7:0] a, logic [7:0] b, logic [7:0] c);
        @(negedge clk);
        clk_sel = 1'b0;
        edge_sel = e;
        sclk_i = e;
        repeat (5) @(negedge clk);
        chk("R3", sclk_oe, 0);
        chk("R3", sclk_o, 1);
        write_byte(a);
        chk("R11", done_flag, 0);
        ext_char(a, "R6", 1'b1, b);
        chk("R11", done_flag, 1);
        ext_char(b, "R8", 1'b0, 8'h00);
        ext_edge(1'b1);
        chk("R10", txd, 1);
        chk("R10", underrun, 1);
        ext_edge(1'b0);
        chk("R10", underrun, 1);
        write_byte(c);
        chk("R10", underrun, 0);
        ext_char(c, "R6", 1'b0, 8'h00);
        chk("R11", done_flag, 1);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", txd, 1);
        chk("R1", sclk_o, 1);
        chk("R1", done_pulse, 0);
        chk("R1", done_flag, 0);
        chk("R1", underrun, 0);
        chk("R3", sclk_oe, 1);

        int_xfer(8'h01, 1'b0);
        int_xfer(8'h80, 1'b0);
        int_xfer(8'h00, 1'b0);
        int_xfer(8'hFF, 1'b0);
        int_xfer(8'hA5, 1'b1);
        for (int i = 0; i < 4; i++) begin
            int_xfer(8'($urandom), 1'b0);
            repeat ($urandom % 4) @(negedge clk);
        end

        ext_session(1'b0, 8'($urandom), 8'($urandom), 8'h81);
        ext_session(1'b1, 8'($urandom), 8'($urandom), 8'h7E);

        @(negedge clk);
        clk_sel = 1'b1;
        repeat (3) @(negedge clk);
        chk("R3", sclk_oe, 1);
        int_xfer(8'($urandom), 1'b1);

        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end
endmodule